// File: doc/BRIEF.md
# Split-Bus Data Tenure Tracker

This block follows the data phase of a split-transaction processor bus for one bus master. Each address start that opens a data transfer is queued with its burst flag, its direction and whether a local cache will serve it. The block then watches the data-bus grant from the arbiter. It takes a grant only when no other device holds the shared data-busy line, and it then raises its own data-busy output for the length of the transfer.

While a tenure is open the block counts transfer acknowledges: one for a single transfer, a parameterised burst length for a burst. It ends the tenure on the last acknowledge with a done pulse. A transfer error or an address retry ends it early with an abort pulse instead. After any tenure ends, one idle turnaround cycle is kept before the next one may start. The exception is fast mode: when a read served by the cache is followed by another such read, and the arbiter grants in the cycle of the last acknowledge, the two tenures stream with no gap.

The queue holds two outstanding transfers. An address start that finds the queue full is flagged and dropped.

Top module: `tdt_tracker`

## Requirements
- R1: After synchronous reset, `busy_o`, `mdrive_o`, `done_o`, `abort_o` and `ovf_o` are 0 and `pend_o` is 0.
- R2: A grant is taken only in a cycle with `gnt_i`=1 and `busy_i`=0, with no tenure open, outside a turnaround cycle, and with at least one transfer queued. Otherwise `busy_o` stays 0.
- R3: A tenure needs BURST_LEN (default 4) acknowledges on `ack_i` when its `burst_i` was 1 at the start, and one when it was 0. `done_o` pulses for one cycle in the cycle after the last acknowledge. Acknowledges with no tenure open are ignored.
- R4: `busy_o` goes to 1 in the cycle after a taken grant and stays 1 until the tenure ends.
- R5: `mdrive_o` is 1 while `busy_o` is 1 and the open transfer is a write (`read_i`=0). It is 0 for reads.
- R6: `err_i` or `retry_i` during an open tenure ends it. `abort_o` pulses the next cycle and there is no `done_o`. The beat count restarts, so the next tenure needs its full number of acknowledges. `retry_i` with no tenure open but a transfer queued drops the oldest queued transfer, with an `abort_o` pulse.
- R7: After any tenure ends without streaming, `busy_o` stays 0 for at least one cycle, and a grant in that cycle is ignored.
- R8: At most DEPTH (default 2) transfers are queued. A `start_i` that finds the queue full is dropped, and `ovf_o` pulses the next cycle.
- R9: If `fast_i`=1, and both the ending transfer and the next queued one are cache-served reads (`read_i`=1, `hit_i`=1), and a grant is taken in the cycle of the last acknowledge, then `busy_o` stays 1 and the next tenure starts at once.
- R10: `pend_o` gives the number of queued transfers, including the one whose tenure is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Address start of a data transfer |
| burst_i | input | 1 | Burst flag, sampled with start_i |
| read_i | input | 1 | 1 for read, 0 for write, sampled with start_i |
| hit_i | input | 1 | Transfer served by the local cache, sampled with start_i |
| fast_i | input | 1 | Enables streaming of back-to-back cache reads |
| gnt_i | input | 1 | Data-bus grant from the arbiter |
| busy_i | input | 1 | Data-busy asserted by another device |
| ack_i | input | 1 | Transfer acknowledge |
| err_i | input | 1 | Transfer error |
| retry_i | input | 1 | Address retry |
| busy_o | output | 1 | Own data-busy |
| mdrive_o | output | 1 | Master drives the data bus |
| done_o | output | 1 | Normal completion pulse |
| abort_o | output | 1 | Early termination pulse |
| ovf_o | output | 1 | Dropped start pulse |
| pend_o | output | $clog2(DEPTH+1) | Queued transfer count |

## Verification
A beat counter that was not cleared by an abort shows up on the next burst: `done_o` arrives one or more acknowledges early, within that tenure. A stuck turnaround or a wrong stream decision shows in the first cycle after the last acknowledge, where `busy_o` is either held or dropped against expectation. A queue pointer or count error shows in `pend_o` and `mdrive_o` at the next start or end of a tenure.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

    typedef struct packed {
        logic burst;
        logic rd;
        logic hit;
    } xact_t;

    // both the finishing and the following transfer are reads served by the cache
    function automatic logic may_stream(xact_t cur, xact_t nxt);
        return cur.rd & cur.hit & nxt.rd & nxt.hit;
    endfunction

endpackage

// File: rtl/tdt_queue.sv
module tdt_queue
    import tdt_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  xact_t         din,
    input  logic          pop,
    output xact_t         head,
    output xact_t         second,
    output logic [CW-1:0] count
);
    xact_t         mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;

    function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head   = mem[rptr];
    assign second = mem[wrap_inc(rptr)];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= din;
                wptr      <= wrap_inc(wptr);
            end
            if (pop) rptr <= wrap_inc(rptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/tdt_beats.sv
module tdt_beats #(
    parameter int BURST_LEN = 4,
    localparam int BW = $clog2(BURST_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic burst,
    output logic last
);
    logic [BW-1:0] cnt;

    assign last = burst ? (cnt == BW'(BURST_LEN - 1)) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tdt_tracker.sv
module tdt_tracker
    import tdt_pkg::*;
#(
    parameter int DEPTH     = 2,
    parameter int BURST_LEN = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          burst_i,
    input  logic          read_i,
    input  logic          hit_i,
    input  logic          fast_i,
    input  logic          gnt_i,
    input  logic          busy_i,
    input  logic          ack_i,
    input  logic          err_i,
    input  logic          retry_i,
    output logic          busy_o,
    output logic          mdrive_o,
    output logic          done_o,
    output logic          abort_o,
    output logic          ovf_o,
    output logic [CW-1:0] pend_o
);
    xact_t   head, second, incoming;
    logic    active, gap;
    logic    full, has_one, has_two;
    logic    grant_ok, take, abort_open, abort_idle, last_ack, stream;
    logic    push, pop, beat_last, beat_clr, beat_inc;

    assign incoming = '{burst: burst_i, rd: read_i, hit: hit_i};
    assign full     = (pend_o == CW'(DEPTH));
    assign has_one  = (pend_o != '0);
    assign has_two  = (pend_o >= CW'(2));

    // grant qualified by nobody else holding the data bus
    assign grant_ok   = gnt_i & ~busy_i;
    assign abort_open = active & (err_i | retry_i);
    assign abort_idle = ~active & retry_i & has_one;
    assign take       = grant_ok & ~active & ~gap & has_one & ~abort_idle;
    assign last_ack   = active & ack_i & ~err_i & ~retry_i & beat_last;
    assign stream     = last_ack & fast_i & has_two & grant_ok & may_stream(head, second);

    assign push = start_i & ~full;
    assign pop  = abort_open | abort_idle | last_ack;

    assign beat_clr = take | abort_open | last_ack;
    assign beat_inc = active & ack_i & ~err_i & ~retry_i & ~beat_last;

    tdt_queue #(.DEPTH(DEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .din    (incoming),
        .pop    (pop),
        .head   (head),
        .second (second),
        .count  (pend_o)
    );

    tdt_beats #(.BURST_LEN(BURST_LEN)) u_beats (
        .clk   (clk),
        .rst   (rst),
        .clr   (beat_clr),
        .inc   (beat_inc),
        .burst (head.burst),
        .last  (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            gap     <= 1'b0;
            done_o  <= 1'b0;
            abort_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            active  <= take | stream | (active & ~abort_open & ~last_ack);
            gap     <= (abort_open | last_ack) & ~stream;
            done_o  <= last_ack;
            abort_o <= abort_open | abort_idle;
            ovf_o   <= start_i & full;
        end
    end

    assign busy_o   = active;
    assign mdrive_o = active & ~head.rd;
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
    parameter int DEPTH = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          gnt_i,
    input logic          busy_i,
    input logic          ack_i,
    input logic          err_i,
    input logic          retry_i,
    input logic          busy_o,
    input logic          mdrive_o,
    input logic          done_o,
    input logic          abort_o,
    input logic          ovf_o,
    input logic [CW-1:0] pend_o
);
    AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(gnt_i && !busy_i)); // R4
    AST_NO_TAKE_WHEN_SHARED: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !busy_o) |=> !busy_o); // R2
    AST_DONE_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(ack_i && busy_o)); // R3
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(err_i || retry_i)); // R6
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && abort_o)); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |=> !busy_o); // R7
    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        pend_o <= CW'(DEPTH)); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(start_i) && $past(pend_o) == CW'(DEPTH))); // R8
    AST_DRIVE_IN_TENURE: assert property (@(posedge clk) disable iff (rst)
        mdrive_o |-> busy_o); // R5
endmodule

bind tdt_tracker tdt_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .gnt_i    (gnt_i),
    .busy_i   (busy_i),
    .ack_i    (ack_i),
    .err_i    (err_i),
    .retry_i  (retry_i),
    .busy_o   (busy_o),
    .mdrive_o (mdrive_o),
    .done_o   (done_o),
    .abort_o  (abort_o),
    .ovf_o    (ovf_o),
    .pend_o   (pend_o)
);

// File: tb/tb_tdt_tracker.sv
module tb_tdt_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;
    localparam int BURST_LEN  = 4;
    localparam int CW         = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, burst_i = 0, read_i = 0, hit_i = 0, fast_i = 0;
    logic gnt_i = 0, busy_i = 0, ack_i = 0, err_i = 0, retry_i = 0;
    logic busy_o, mdrive_o, done_o, abort_o, ovf_o;
    logic [CW-1:0] pend_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdt_tracker #(.DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .burst_i(burst_i), .read_i(read_i),
        .hit_i(hit_i), .fast_i(fast_i), .gnt_i(gnt_i), .busy_i(busy_i), .ack_i(ack_i),
        .err_i(err_i), .retry_i(retry_i), .busy_o(busy_o), .mdrive_o(mdrive_o),
        .done_o(done_o), .abort_o(abort_o), .ovf_o(ovf_o), .pend_o(pend_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_i = 0; gnt_i = 0; busy_i = 0; ack_i = 0; err_i = 0; retry_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 drive", mdrive_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 abort", abort_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 pend", pend_o, 0);

        // R2 grant with nothing queued is ignored
        gnt_i = 1; tick();
        chk("R2 empty grant", busy_o, 0);
        // R3 acknowledge with no tenure is ignored
        gnt_i = 0; ack_i = 1; tick(); ack_i = 0;
        chk("R3 stray ack", done_o, 0);
        tick();

        // sweep: burst, direction, cache hit, fast mode, end kind (0 normal, 1 error, 2 retry)
        for (int b = 0; b < 2; b++)
        for (int r = 0; r < 2; r++)
        for (int h = 0; h < 2; h++)
        for (int f = 0; f < 2; f++)
        for (int k = 0; k < 3; k++) begin
            automatic int need = b ? BURST_LEN : 1;
            automatic bit exp_stream;
            idle_inputs();
            fast_i = f[0]; burst_i = b[0]; read_i = r[0]; hit_i = h[0];
            start_i = 1; tick(); tick(); start_i = 0;
            chk("R10 two queued", pend_o, 2);
            gnt_i = 1; busy_i = 1; tick();
            chk("R2 shared bus", busy_o, 0);
            busy_i = 0; tick();
            chk("R4 busy after grant", busy_o, 1);
            chk("R5 drive dir", mdrive_o, r ? 0 : 1);
            if (k == 0) begin
                for (int i = 0; i < need - 1; i++) begin
                    ack_i = 1; tick();
                    chk("R4 held", busy_o, 1);
                    chk("R3 early done", done_o, 0);
                end
                ack_i = 1; tick(); ack_i = 0;
                exp_stream = f[0] & r[0] & h[0];
                chk("R3 done", done_o, 1);
                chk("R9 stream", busy_o, exp_stream ? 1 : 0);
            end else begin
                if (need > 1) begin ack_i = 1; tick(); ack_i = 0; end
                err_i = (k == 1); retry_i = (k == 2); tick();
                err_i = 0; retry_i = 0;
                exp_stream = 0;
                chk("R6 abort", abort_o, 1);
                chk("R6 no done", done_o, 0);
                chk("R6 busy end", busy_o, 0);
            end
            chk("R10 one left", pend_o, 1);
            if (!exp_stream) begin
                tick();
                chk("R7 turnaround", busy_o, 0);
                tick();
                chk("R4 second grant", busy_o, 1);
            end
            gnt_i = 0;
            for (int i = 0; i < need - 1; i++) begin
                ack_i = 1; tick();
                chk("R6 count restart", done_o, 0);
            end
            ack_i = 1; tick(); ack_i = 0;
            chk("R3 second done", done_o, 1);
            chk("R10 drained", pend_o, 0);
            tick();
        end

        // R8 overflow
        idle_inputs();
        start_i = 1; tick(); tick();
        chk("R8 no ovf at fill", ovf_o, 0);
        tick(); start_i = 0;
        chk("R8 ovf", ovf_o, 1);
        chk("R8 pend bound", pend_o, 2);
        tick();
        chk("R8 ovf pulse", ovf_o, 0);
        // R6 retry with no tenure drops the oldest queued
        retry_i = 1; tick();
        chk("R6 idle retry", abort_o, 1);
        chk("R6 idle pop", pend_o, 1);
        tick(); retry_i = 0;
        chk("R6 idle pop 2", pend_o, 0);
        chk("R6 idle busy", busy_o, 0);
        tick();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule